// File: doc/BRIEF.md
# Serial Transceiver with Receive-Throttled DTR

This block is an asynchronous serial port for a small processor. It sends and receives 8N1 characters, one start bit, eight data bits least significant first and one stop bit, and the processor reaches it through a byte-wide register window. A prescaler divides the system clock into an internal tick. A half-bit count, held in a register the processor writes, sets how many ticks make half a bit. One bit lasts two half-bits. With the default divide-by-27 and a half-bit count of 1, a 6.25 MHz clock gives 54 clocks per bit, which is close enough to 115200 baud.

The receiver holds one character and has no buffer. A DTR output throttles the far end. It goes low as soon as a start edge is seen and comes back high only when the processor has read the character. A one-clock interrupt strobe marks each character that is stored. A second strobe marks each character whose transmission has finished.

Register window (addr): 0 = data (read returns the received byte, write loads the transmitter); 1 = status, with bit 0 receive-ready, bit 1 transmit-empty, bit 2 framing error, bit 3 overrun and the upper bits zero; 2 = half-bit count, read/write. Address 3 reads zero and ignores writes.

Top module: `serdtr_top`

## Requirements
- R1: After reset txd and dtr are 1, status reads 0x02, the half-bit register reads HB_RESET (1), the data register reads 0x00, and both strobes are 0.
- R2: One bit on the line lasts 2*H*DIV clocks, where H is the half-bit register. A written value of 0 behaves as 1. The register reads back what was written.
- R3: A character received 8N1, LSB first, sets status bit 0, and a read of address 0 returns it.
- R4: dtr falls no later than 3 clocks after rxd falls from idle, and it stays low while a received byte is unread.
- R5: dtr is high again on the clock after a read of address 0, as long as no frame is in progress.
- R6: A start edge is re-checked at the half-bit point. If the line has returned high, the frame is dropped: nothing is stored, no strobe is given and dtr returns high.
- R7: A stop bit sampled low stores the byte and also sets status bit 2. A new frame starts only on a high-to-low edge of rxd.
- R8: A frame that completes while a byte is still unread sets status bit 3, and the held byte is kept unchanged.
- R9: A read of address 0 clears status bits 0, 2 and 3.
- R10: A write to address 0 while status bit 1 is set loads the byte and clears bit 1. It then sends start, eight data bits LSB first and a stop bit on txd, and sets bit 1 again.
- R11: A write to address 0 while a transmission is in progress is ignored.
- R12: rx_irq pulses for one clock per stored byte, and tx_irq pulses for one clock per finished frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register access select |
| we | input | 1 | Write strobe, qualified by cs |
| rd | input | 1 | Read strobe, qualified by cs; a data read consumes the byte |
| addr | input | 2 | Register address |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Read data, combinational from addr |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| dtr | output | 1 | High when ready to accept a character |
| rx_irq | output | 1 | One-clock strobe per stored character |
| tx_irq | output | 1 | One-clock strobe per sent character |

## Verification
The hardest states to reach are the ones in which the far end disobeys or the line misbehaves. The remote sender normally honours DTR, so the bench has to drive a second frame while the first byte is still unread in order to produce an overrun. It holds the stop bit low to provoke a framing error. It pulls rxd low for a fraction of a half bit, after first raising the half-bit count so the glitch is plainly shorter than the re-check point. The bit period is measured on txd between edges of an alternating pattern, so the unknown phase of the prescaler against the start of the frame does not affect the count.

// File: rtl/serdtr_pkg.sv
`timescale 1ns/1ps
package serdtr_pkg;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_START = 2'd1,
      S_DATA  = 2'd2,
      S_STOP  = 2'd3
   } ser_state_t;

   localparam logic [1:0] A_DATA = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_HALF = 2'd2;

endpackage

// File: rtl/serdtr_prescale.sv
`timescale 1ns/1ps
module serdtr_prescale #(
   parameter int DIV = 27
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   generate
      if (DIV == 1) begin : g_passthru
         assign tick = 1'b1;
      end else begin : g_count
         localparam int PCW = $clog2(DIV);
         logic [PCW-1:0] pcnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pcnt <= '0;
               tick <= 1'b0;
            end else if (pcnt == PCW'(DIV - 1)) begin
               pcnt <= '0;
               tick <= 1'b1;
            end else begin
               pcnt <= pcnt + 1'b1;
               tick <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/serdtr_rx.sv
`timescale 1ns/1ps
module serdtr_rx import serdtr_pkg::*; #(
   parameter int DW   = 8,
   parameter int CW   = 9,
   parameter int SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          rxd,
   input  logic [CW-1:0] half_m1,
   input  logic [CW-1:0] full_m1,
   input  logic          rd_ack,
   output logic [DW-1:0] rx_data,
   output logic          rx_ready,
   output logic          ferr,
   output logic          ovr,
   output logic          busy,
   output logic          rx_irq
);

   localparam int BW = (DW > 1) ? $clog2(DW) : 1;

   logic [SYNC-1:0] sync_q;
   logic            line, line_d;
   ser_state_t      st;
   logic [CW-1:0]   cnt;
   logic [BW-1:0]   bitn;
   logic [DW-1:0]   shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC-2:0], rxd};
   end

   assign line = sync_q[SYNC-1];
   assign busy = (st != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_d   <= 1'b1;
         st       <= S_IDLE;
         cnt      <= '0;
         bitn     <= '0;
         shreg    <= '0;
         rx_data  <= '0;
         rx_ready <= 1'b0;
         ferr     <= 1'b0;
         ovr      <= 1'b0;
         rx_irq   <= 1'b0;
      end else begin
         line_d <= line;
         rx_irq <= 1'b0;
         if (rd_ack) begin
            rx_ready <= 1'b0;
            ferr     <= 1'b0;
            ovr      <= 1'b0;
         end
         case (st)
            S_IDLE: begin
               cnt <= '0;
               if (line_d && !line) st <= S_START;
            end
            S_START: if (tick) begin
               if (cnt == half_m1) begin
                  cnt  <= '0;
                  bitn <= '0;
                  st   <= line ? S_IDLE : S_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_DATA: if (tick) begin
               if (cnt == full_m1) begin
                  cnt   <= '0;
                  shreg <= {line, shreg[DW-1:1]};
                  if (bitn == BW'(DW - 1)) st <= S_STOP;
                  else                     bitn <= bitn + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_STOP: if (tick) begin
               if (cnt == full_m1) begin
                  cnt <= '0;
                  st  <= S_IDLE;
                  if (rx_ready && !rd_ack) begin
                     ovr <= 1'b1;
                  end else begin
                     rx_data  <= shreg;
                     rx_ready <= 1'b1;
                     ferr     <= !line;
                     rx_irq   <= 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/serdtr_tx.sv
`timescale 1ns/1ps
module serdtr_tx import serdtr_pkg::*; #(
   parameter int DW = 8,
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [CW-1:0] full_m1,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic          txd,
   output logic          tx_empty,
   output logic          tx_irq
);

   localparam int BW = (DW > 1) ? $clog2(DW) : 1;

   ser_state_t    st;
   logic [CW-1:0] cnt;
   logic [BW-1:0] bitn;
   logic [DW-1:0] shreg;
   logic          bit_end;

   assign bit_end = tick && (cnt == full_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cnt      <= '0;
         bitn     <= '0;
         shreg    <= '0;
         txd      <= 1'b1;
         tx_empty <= 1'b1;
         tx_irq   <= 1'b0;
      end else begin
         tx_irq <= 1'b0;
         if (st != S_IDLE && tick) cnt <= bit_end ? '0 : cnt + 1'b1;
         case (st)
            S_IDLE: if (wr) begin
               shreg    <= wdata;
               cnt      <= '0;
               txd      <= 1'b0;
               tx_empty <= 1'b0;
               st       <= S_START;
            end
            S_START: if (bit_end) begin
               txd   <= shreg[0];
               shreg <= shreg >> 1;
               bitn  <= '0;
               st    <= S_DATA;
            end
            S_DATA: if (bit_end) begin
               if (bitn == BW'(DW - 1)) begin
                  txd <= 1'b1;
                  st  <= S_STOP;
               end else begin
                  bitn  <= bitn + 1'b1;
                  txd   <= shreg[0];
                  shreg <= shreg >> 1;
               end
            end
            S_STOP: if (bit_end) begin
               tx_empty <= 1'b1;
               tx_irq   <= 1'b1;
               st       <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/serdtr_top.sv
`timescale 1ns/1ps
module serdtr_top import serdtr_pkg::*; #(
   parameter int DIV      = 27,
   parameter int HB_W     = 8,
   parameter int HB_RESET = 1,
   parameter int DW       = 8,
   parameter int SYNC     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs,
   input  logic          we,
   input  logic          rd,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          rxd,
   output logic          txd,
   output logic          dtr,
   output logic          rx_irq,
   output logic          tx_irq
);

   localparam int CW = HB_W + 1;

   generate
      if (DIV < 1)        begin : g_bad_div  $error("DIV must be at least 1");      end
      if (HB_W > DW)      begin : g_bad_hbw  $error("HB_W must not exceed DW");     end
      if (DW < 4)         begin : g_bad_dw   $error("DW must be at least 4");       end
      if (SYNC < 2)       begin : g_bad_sync $error("SYNC must be at least 2");     end
      if (HB_RESET < 0 || HB_RESET >= (1 << HB_W))
                          begin : g_bad_hbr  $error("HB_RESET out of range");       end
   endgenerate

   logic            tick;
   logic [HB_W-1:0] hb, hbe;
   logic [CW-1:0]   half_m1, full_m1;
   logic            rd_ack, wr_tx;
   logic [DW-1:0]   rx_data;
   logic            rx_ready, ferr, ovr, rx_busy, tx_empty;

   assign rd_ack = cs && rd && (addr == A_DATA);
   assign wr_tx  = cs && we && (addr == A_DATA) && tx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          hb <= HB_W'(HB_RESET);
      else if (cs && we && addr == A_HALF) hb <= wdata[HB_W-1:0];
   end

   always_comb begin
      hbe     = (hb == '0) ? HB_W'(1) : hb;
      half_m1 = {1'b0, hbe} - CW'(1);
      full_m1 = {hbe, 1'b0} - CW'(1);
   end

   serdtr_prescale #(.DIV(DIV)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   serdtr_rx #(.DW(DW), .CW(CW), .SYNC(SYNC)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .rxd      (rxd),
      .half_m1  (half_m1),
      .full_m1  (full_m1),
      .rd_ack   (rd_ack),
      .rx_data  (rx_data),
      .rx_ready (rx_ready),
      .ferr     (ferr),
      .ovr      (ovr),
      .busy     (rx_busy),
      .rx_irq   (rx_irq)
   );

   serdtr_tx #(.DW(DW), .CW(CW)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .full_m1  (full_m1),
      .wr       (wr_tx),
      .wdata    (wdata),
      .txd      (txd),
      .tx_empty (tx_empty),
      .tx_irq   (tx_irq)
   );

   assign dtr = !rx_busy && !rx_ready;

   always_comb begin
      case (addr)
         A_DATA:  rdata = rx_data;
         A_STAT:  rdata = DW'({ovr, ferr, tx_empty, rx_ready});
         A_HALF:  rdata = DW'(hb);
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/serdtr_chk.sv
`timescale 1ns/1ps
module serdtr_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs,
   input logic          we,
   input logic          rd,
   input logic [1:0]    addr,
   input logic          dtr,
   input logic          txd,
   input logic          rx_ready,
   input logic          tx_empty,
   input logic          rx_irq,
   input logic          tx_irq,
   input logic [DW-1:0] rx_data
);

   logic data_rd, data_wr;
   assign data_rd = cs && rd && (addr == 2'd0);
   assign data_wr = cs && we && (addr == 2'd0);

   p_dtr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> !dtr);

   p_dtr_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dtr) && $past(rx_ready)) |-> $past(data_rd));

   p_byte_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && !data_rd) |=> (rx_ready && $stable(rx_data)));

   p_tx_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_empty) |-> $past(data_wr));

   p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> txd);

   p_rx_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (rx_ready && !$past(rx_irq)));

   p_tx_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> (tx_empty && !$past(tx_irq)));

endmodule

bind serdtr_top serdtr_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs       (cs),
   .we       (we),
   .rd       (rd),
   .addr     (addr),
   .dtr      (dtr),
   .txd      (txd),
   .rx_ready (rx_ready),
   .tx_empty (tx_empty),
   .rx_irq   (rx_irq),
   .tx_irq   (tx_irq),
   .rx_data  (rx_data)
);

// File: tb/sim_serdtr_top.sv
`timescale 1ns/1ps
module sim_serdtr_top;

   localparam int DIV  = 27;
   localparam int BIT1 = 2 * DIV;
   localparam int NV   = 6;
   localparam logic [7:0] VEC [NV] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81, 8'h3C};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0, we = 1'b0, rd = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       rxd = 1'b1;
   logic       txd, dtr, rx_irq, tx_irq;

   int nchk = 0, nfail = 0;
   int rx_irq_n = 0, tx_irq_n = 0;
   logic dtr_seen;

   always #2.5 clk = ~clk;

   serdtr_top u0 (
      .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .rd(rd), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .dtr(dtr),
      .rx_irq(rx_irq), .tx_irq(tx_irq)
   );

   always @(posedge clk) begin
      if (rst_n && rx_irq) rx_irq_n++;
      if (rst_n && tx_irq) tx_irq_n++;
   end

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; we = 1'b0;
   endtask

   task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      cs = 1'b0; rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic rx_send(input logic [7:0] b, input bit stop_hi, input int bitclk);
      @(negedge clk);
      rxd = 1'b0;
      repeat (3) @(negedge clk);
      dtr_seen = dtr;
      repeat (bitclk - 3) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (bitclk) @(negedge clk);
      end
      rxd = stop_hi;
      repeat (bitclk) @(negedge clk);
      rxd = 1'b1;
      repeat (bitclk) @(negedge clk);
   endtask

   task automatic tx_capture(input int bitclk, output logic [7:0] b, output logic stop);
      while (txd !== 1'b0) @(negedge clk);
      repeat (bitclk + bitclk / 2 - DIV / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         b[i] = txd;
         repeat (bitclk) @(negedge clk);
      end
      stop = txd;
   endtask

   task automatic measure_bit(output int n);
      cpu_wr(2'd0, 8'h55);
      while (txd !== 1'b0) @(negedge clk);
      while (txd !== 1'b1) @(negedge clk);
      n = 0;
      while (txd !== 1'b0) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic       sb;
      int         n, base;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(txd === 1'b1, "R1 txd", 16'(txd), 16'h1);
      chk(dtr === 1'b1, "R1 dtr", 16'(dtr), 16'h1);
      peek(2'd1, d); chk(d === 8'h02, "R1 status", 16'(d), 16'h02);
      peek(2'd2, d); chk(d === 8'h01, "R1 half reg", 16'(d), 16'h01);
      peek(2'd0, d); chk(d === 8'h00, "R1 data", 16'(d), 16'h00);
      chk(rx_irq === 1'b0 && tx_irq === 1'b0, "R1 strobes", 16'({rx_irq, tx_irq}), 16'h0);

      // table walk: receive, consume, transmit
      for (int v = 0; v < NV; v++) begin
         rx_send(VEC[v], 1'b1, BIT1);
         chk(dtr_seen === 1'b0, "R4 dtr fall", 16'(dtr_seen), 16'h0);
         chk(dtr === 1'b0, "R4 dtr held", 16'(dtr), 16'h0);
         peek(2'd1, d); chk(d === 8'h03, "R3 status ready", 16'(d), 16'h03);
         cpu_rd(2'd0, d); chk(d === VEC[v], "R3 data", 16'(d), 16'(VEC[v]));
         chk(dtr === 1'b1, "R5 dtr release", 16'(dtr), 16'h1);
         peek(2'd1, d); chk(d === 8'h02, "R9 ready cleared", 16'(d), 16'h02);
         cpu_wr(2'd0, VEC[v]);
         peek(2'd1, d); chk(d[1] === 1'b0, "R10 busy flag", 16'(d), 16'h00);
         tx_capture(BIT1, d, sb);
         chk(d === VEC[v], "R10 tx byte", 16'(d), 16'(VEC[v]));
         chk(sb === 1'b1, "R10 stop bit", 16'(sb), 16'h1);
         repeat (BIT1) @(negedge clk);
         peek(2'd1, d); chk(d === 8'h02, "R10 empty again", 16'(d), 16'h02);
      end
      chk(rx_irq_n == NV, "R12 rx strobes", 16'(rx_irq_n), 16'(NV));
      chk(tx_irq_n == NV, "R12 tx strobes", 16'(tx_irq_n), 16'(NV));

      // R2 bit period and half-bit register
      cpu_wr(2'd2, 8'h02);
      peek(2'd2, d); chk(d === 8'h02, "R2 readback", 16'(d), 16'h02);
      measure_bit(n); chk(n == 4 * DIV, "R2 period H=2", 16'(n), 16'(4 * DIV));
      repeat (12 * 4 * DIV) @(negedge clk);
      cpu_wr(2'd2, 8'h00);
      measure_bit(n); chk(n == BIT1, "R2 period H=0", 16'(n), 16'(BIT1));
      repeat (12 * BIT1) @(negedge clk);

      // R6 short glitch with a long half-bit
      cpu_wr(2'd2, 8'h04);
      base = rx_irq_n;
      @(negedge clk); rxd = 1'b0;
      repeat (20) @(negedge clk); rxd = 1'b1;
      repeat (8 * DIV) @(negedge clk);
      peek(2'd1, d); chk(d === 8'h02, "R6 nothing stored", 16'(d), 16'h02);
      chk(dtr === 1'b1, "R6 dtr back", 16'(dtr), 16'h1);
      chk(rx_irq_n == base, "R6 no strobe", 16'(rx_irq_n), 16'(base));

      // R7 framing error
      cpu_wr(2'd2, 8'h01);
      rx_send(8'h5A, 1'b0, BIT1);
      peek(2'd1, d); chk(d === 8'h07, "R7 framing flag", 16'(d), 16'h07);
      cpu_rd(2'd0, d); chk(d === 8'h5A, "R7 byte kept", 16'(d), 16'h5A);
      peek(2'd1, d); chk(d === 8'h02, "R9 framing cleared", 16'(d), 16'h02);

      // R8 overrun
      rx_send(8'h11, 1'b1, BIT1);
      rx_send(8'h22, 1'b1, BIT1);
      peek(2'd1, d); chk(d === 8'h0B, "R8 overrun flag", 16'(d), 16'h0B);
      cpu_rd(2'd0, d); chk(d === 8'h11, "R8 first byte kept", 16'(d), 16'h11);
      peek(2'd1, d); chk(d === 8'h02, "R9 overrun cleared", 16'(d), 16'h02);
      chk(rx_irq_n == NV + 2, "R12 rx total", 16'(rx_irq_n), 16'(NV + 2));

      // R11 write while busy
      cpu_wr(2'd0, 8'hC3);
      cpu_wr(2'd0, 8'h7E);
      tx_capture(BIT1, d, sb);
      chk(d === 8'hC3, "R11 first byte sent", 16'(d), 16'hC3);
      repeat (BIT1) @(negedge clk);
      n = 0;
      for (int i = 0; i < 3 * BIT1; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) n++;
      end
      chk(n == 0, "R11 no second frame", 16'(n), 16'h0);
      chk(tx_irq_n == NV + 3, "R12 tx total", 16'(tx_irq_n), 16'(NV + 3));

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule